// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block sits between a simple register bus and an external successive-approximation converter fronted by an analog multiplexer. It holds the selected input, enforces a programmable settling time after every input change, and starts conversions on the converter's start line. It takes the result when the converter signals end of conversion and holds it in a data register that software can read.

Software can drive a measurement step by step: select the input, wait for the status to go idle, start, wait again, then read. Two shortcuts skip steps. A read of the restart register returns the previous result and launches the next conversion in the same access. A write to the auto register runs the whole select–settle–convert–capture sequence without any further access. Converter codes are offset binary (code 0 is the negative full-scale end, code 32768 is mid-scale, one code step is one 65536th of the full range). They reach the bus unchanged in the low 16 bits of a 32-bit word.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the status word reads 0, the data word reads 0, `mux_sel` is 1 and `adc_start` is low.
- R2: A write to address 0 while idle takes bits [2:0] as input index i and drives `mux_sel` to the odd line number 2*i+1 (lines 1, 3, ... 15).
- R3: A write to address 0 or 3 while idle starts a settling phase of S cycles, where S is the value last written to address 1 (bits [15:0], reset value 4). During this phase status bit 0 reads 1. After an address-3 write the `adc_start` pulse becomes visible S+1 cycles after the write's clock edge.
- R4: A write to address 2 while idle raises `adc_start` for exactly one cycle, right after the write's edge, and sets status bit 0 (busy).
- R5: The result register changes only on a clock edge where `adc_eoc` is high during a conversion. A read of address 5 returns the captured 16-bit code in bits [15:0] and zero in bits [31:16].
- R6: Busy (status bit 0, address 4) stays 1 for the cycle after the capture edge and reads 0 one cycle later.
- R7: A read of address 6 while idle returns the last result, in the same word format as address 5, and starts a new conversion on the currently selected input.
- R8: A write to address 3 while idle takes bits [2:0] as input index, selects it, settles, converts and captures the result without any further bus access.
- R9: A start, channel, auto or restart request that arrives while busy is ignored: `mux_sel` does not change and no extra `adc_start` pulse occurs. Such a request sets the sticky overrun flag (status bit 1), which a read of address 4 clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (reads of addresses 4 and 6 have side effects) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle `bus_rd` is high, zero otherwise |
| mux_sel | output | 4 | Selected multiplexer line, always odd |
| adc_start | output | 1 | One-cycle conversion start pulse to the converter |
| adc_eoc | input | 1 | End-of-conversion strobe from the converter |
| adc_data | input | 16 | Conversion code, valid while `adc_eoc` is high |

## Verification
The bench builds the block with its default parameters: eight inputs, a 16-bit settle counter and 16-bit codes. Its converter model answers 12 cycles after each start with a code derived from the selected line, so a wrong line shows up as a wrong code. The table varies the settle count from 0 upward. This brings the zero-wait edge case and exact start latencies into reach, together with all three ways of starting a conversion. Directed tests then cover the timing of busy around the capture edge, requests rejected while busy, and results holding across a channel change.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_CHAN    = 3'd0,
    RA_SETTLE  = 3'd1,
    RA_START   = 3'd2,
    RA_AUTO    = 3'd3,
    RA_STATUS  = 3'd4,
    RA_DATA    = 3'd5,
    RA_RESTART = 3'd6
  } reg_addr_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SETTLE,
    SQ_CONVERT,
    SQ_DONE
  } seq_state_e;
endpackage

// File: rtl/adcseq_settle_timer.sv
module adcseq_settle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (run && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

  AST_COUNT_NEVER_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && expired) |=> expired); // R3
endmodule

// File: rtl/adcseq_fsm.sv
module adcseq_fsm
  import adcseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic auto_req,
  input  logic chan_req,
  input  logic settle_expired,
  input  logic adc_eoc,
  output logic busy,
  output logic adc_start,
  output logic timer_load,
  output logic timer_run,
  output logic capture,
  output logic accept,
  output logic reject
);
  seq_state_e state_q;
  logic       auto_pend_q;
  logic       start_q;
  logic       any_req;
  logic       idle;
  logic       settle_req;

  assign idle       = (state_q == SQ_IDLE);
  assign any_req    = start_req | auto_req | chan_req;
  assign settle_req = auto_req | chan_req;
  assign accept     = idle & any_req;
  assign reject     = ~idle & any_req;
  assign timer_load = idle & settle_req;
  assign timer_run  = (state_q == SQ_SETTLE);
  assign capture    = (state_q == SQ_CONVERT) & adc_eoc;
  assign busy       = ~idle;
  assign adc_start  = start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SQ_IDLE;
      auto_pend_q <= 1'b0;
      start_q     <= 1'b0;
    end else begin
      start_q <= 1'b0;
      unique case (state_q)
        SQ_IDLE: begin
          if (settle_req) begin
            state_q     <= SQ_SETTLE;
            auto_pend_q <= auto_req;
          end else if (start_req) begin
            state_q <= SQ_CONVERT;
            start_q <= 1'b1;
          end
        end
        SQ_SETTLE: begin
          if (settle_expired) begin
            if (auto_pend_q) begin
              state_q <= SQ_CONVERT;
              start_q <= 1'b1;
            end else begin
              state_q <= SQ_IDLE;
            end
            auto_pend_q <= 1'b0;
          end
        end
        SQ_CONVERT: begin
          if (adc_eoc) state_q <= SQ_DONE;
        end
        SQ_DONE: state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start); // R4
  AST_START_IN_CONVERT: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> (state_q == SQ_CONVERT)); // R4
  AST_BUSY_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> busy); // R6
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_DONE) |=> !busy); // R6
  AST_REJECT_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (reject && state_q == SQ_CONVERT) |=> !adc_start); // R9
endmodule

// File: rtl/adcseq_regs.sv
module adcseq_regs
  import adcseq_pkg::*;
#(
  parameter int               BUS_W      = 32,
  parameter int               DATA_W     = 16,
  parameter int               SETTLE_W   = 16,
  parameter int               CH_W       = 3,
  parameter logic [SETTLE_W-1:0] SETTLE_RST = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [REG_AW-1:0]   bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic                accept,
  input  logic                reject,
  input  logic                capture,
  input  logic                busy,
  input  logic [DATA_W-1:0]   adc_data,
  output logic                start_req,
  output logic                auto_req,
  output logic                chan_req,
  output logic [CH_W-1:0]     chan_idx,
  output logic [SETTLE_W-1:0] settle_val
);
  logic [DATA_W-1:0] result_q;
  logic              ovr_q;
  logic              status_rd;
  logic              unused_wdata;
  reg_addr_e         addr;

  function automatic logic [BUS_W-1:0] pack_code(input logic [DATA_W-1:0] code);
    return {{(BUS_W-DATA_W){1'b0}}, code};
  endfunction

  assign addr         = reg_addr_e'(bus_addr);
  assign chan_req     = bus_wr && addr == RA_CHAN;
  assign auto_req     = bus_wr && addr == RA_AUTO;
  assign start_req    = (bus_wr && addr == RA_START) || (bus_rd && addr == RA_RESTART);
  assign status_rd    = bus_rd && addr == RA_STATUS;
  assign unused_wdata = ^bus_wdata[BUS_W-1:SETTLE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_idx   <= '0;
      settle_val <= SETTLE_RST;
      result_q   <= '0;
      ovr_q      <= 1'b0;
    end else begin
      if (accept && (chan_req || auto_req)) chan_idx <= bus_wdata[CH_W-1:0];
      if (bus_wr && addr == RA_SETTLE) settle_val <= bus_wdata[SETTLE_W-1:0];
      if (capture) result_q <= adc_data;
      if (reject) ovr_q <= 1'b1;
      else if (status_rd) ovr_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (addr)
        RA_CHAN:    bus_rdata = {{(BUS_W-CH_W){1'b0}}, chan_idx};
        RA_SETTLE:  bus_rdata = {{(BUS_W-SETTLE_W){1'b0}}, settle_val};
        RA_STATUS:  bus_rdata = {{(BUS_W-2){1'b0}}, ovr_q, busy};
        RA_DATA,
        RA_RESTART: bus_rdata = pack_code(result_q);
        default:    bus_rdata = '0;
      endcase
    end
  end

  AST_OVR_ON_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> ovr_q); // R9
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(result_q)); // R5
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adcseq_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int DATA_W     = 16,
  parameter int BUS_W      = 32,
  parameter int SETTLE_W   = 16,
  parameter int SETTLE_RST = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [REG_AW-1:0]           bus_addr,
  input  logic [BUS_W-1:0]            bus_wdata,
  output logic [BUS_W-1:0]            bus_rdata,
  output logic [$clog2(NUM_CH):0]     mux_sel,
  output logic                        adc_start,
  input  logic                        adc_eoc,
  input  logic [DATA_W-1:0]           adc_data
);
  localparam int CH_W  = $clog2(NUM_CH);
  localparam int MUX_W = CH_W + 1;

  logic                start_req, auto_req, chan_req;
  logic                accept, reject, capture, busy;
  logic                timer_load, timer_run, settle_expired;
  logic [CH_W-1:0]     chan_idx;
  logic [SETTLE_W-1:0] settle_val;

  function automatic logic [MUX_W-1:0] odd_line(input logic [CH_W-1:0] idx);
    return {idx, 1'b1};
  endfunction

  assign mux_sel = odd_line(chan_idx);

  adcseq_regs #(
    .BUS_W(BUS_W), .DATA_W(DATA_W), .SETTLE_W(SETTLE_W), .CH_W(CH_W),
    .SETTLE_RST(SETTLE_W'(SETTLE_RST))
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .accept(accept), .reject(reject), .capture(capture), .busy(busy),
    .adc_data(adc_data), .start_req(start_req), .auto_req(auto_req),
    .chan_req(chan_req), .chan_idx(chan_idx), .settle_val(settle_val)
  );

  adcseq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .auto_req(auto_req),
    .chan_req(chan_req), .settle_expired(settle_expired), .adc_eoc(adc_eoc),
    .busy(busy), .adc_start(adc_start), .timer_load(timer_load),
    .timer_run(timer_run), .capture(capture), .accept(accept), .reject(reject)
  );

  adcseq_settle_timer #(.CNT_W(SETTLE_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(timer_load), .load_val(settle_val),
    .run(timer_run), .expired(settle_expired)
  );

  AST_MUX_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mux_sel)); // R9
  AST_MUX_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    mux_sel[0]); // R2
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> busy); // R4
endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  localparam int CLK_PERIOD  = 10;
  localparam int CONV_CYCLES = 12;
  localparam logic [2:0] A_CHAN = 3'd0, A_SETTLE = 3'd1, A_START = 3'd2,
                         A_AUTO = 3'd3, A_STATUS = 3'd4, A_DATA = 3'd5,
                         A_RESTART = 3'd6;

  typedef struct packed {
    logic [1:0] mode;   // 0 manual, 1 auto, 2 restart read
    logic [2:0] ch;
    logic [7:0] settle;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 3'd3, 8'd0},
    '{2'd1, 3'd0, 8'd0},
    '{2'd1, 3'd7, 8'd5},
    '{2'd2, 3'd4, 8'd2},
    '{2'd0, 3'd6, 8'd9},
    '{2'd1, 3'd1, 8'd17},
    '{2'd2, 3'd2, 8'd1},
    '{2'd1, 3'd5, 8'd3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  mux_sel;
  logic        adc_start;
  logic        adc_eoc = 1'b0;
  logic [15:0] adc_data = '0;

  int n_chk = 0, n_bad = 0;
  int stub_left = 0;
  int start_count = 0;
  logic [3:0] stub_mux = '0;
  logic [15:0] last_code = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mux_sel(mux_sel), .adc_start(adc_start), .adc_eoc(adc_eoc),
    .adc_data(adc_data)
  );

  // converter model: answers CONV_CYCLES after a start with a line-dependent code
  always @(posedge clk) begin
    adc_eoc <= 1'b0;
    if (adc_start) begin
      stub_left   <= CONV_CYCLES;
      stub_mux    <= mux_sel;
      start_count <= start_count + 1;
    end else if (stub_left > 1) begin
      stub_left <= stub_left - 1;
    end else if (stub_left == 1) begin
      stub_left <= 0;
      adc_eoc   <= 1'b1;
      adc_data  <= ({12'h0, stub_mux} * 16'd4097) ^ 16'h8000;
    end
  end

  function automatic logic [15:0] expect_code(input int idx);
    int line;
    line = 2 * idx + 1;
    return 16'((line * 4097) ^ 32'h8000);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    s = 32'h1;
    for (int k = 0; k < 2000 && s[0]; k++) bus_read(A_STATUS, s);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int n;
    int sc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 mux_sel", {28'h0, mux_sel}, 32'd1);
    check("R1 adc_start", {31'h0, adc_start}, 32'd0);
    bus_read(A_STATUS, rd); check("R1 status", rd, 32'd0);
    bus_read(A_DATA, rd);   check("R1 data", rd, 32'd0);

    foreach (VECS[i]) begin
      bus_write(A_SETTLE, {24'h0, VECS[i].settle});
      case (VECS[i].mode)
        2'd1: begin
          bus_write(A_AUTO, {29'h0, VECS[i].ch});
          n = 0;
          while (!adc_start && n < 1000) begin
            @(posedge clk); n++; @(negedge clk);
          end
          check("R3 auto start latency", n, VECS[i].settle + 1);
          wait_idle();
          last_code = expect_code(VECS[i].ch);
          bus_read(A_DATA, rd);
          check("R8 auto result", rd, {16'h0, last_code});
        end
        2'd2: begin
          bus_write(A_CHAN, {29'h0, VECS[i].ch});
          wait_idle();
          bus_read(A_RESTART, rd);
          check("R7 restart returns last", rd, {16'h0, last_code});
          wait_idle();
          last_code = expect_code(VECS[i].ch);
          bus_read(A_DATA, rd);
          check("R7 restart new result", rd, {16'h0, last_code});
        end
        default: begin
          bus_write(A_CHAN, {29'h0, VECS[i].ch});
          check("R2 mux line", {28'h0, mux_sel}, 2 * VECS[i].ch + 1);
          bus_read(A_STATUS, rd);
          check("R3 settle busy", rd[0], (VECS[i].settle > 0) ? 32'd1 : 32'd0);
          wait_idle();
          @(negedge clk);
          bus_wr = 1'b1; bus_addr = A_START;
          @(negedge clk);
          bus_wr = 1'b0;
          check("R4 start pulse", {31'h0, adc_start}, 32'd1);
          @(negedge clk);
          check("R4 start one cycle", {31'h0, adc_start}, 32'd0);
          wait_idle();
          last_code = expect_code(VECS[i].ch);
          bus_read(A_DATA, rd);
          check("R5 data word", rd, {16'h0, last_code});
        end
      endcase
    end

    // R6 busy timing around capture
    bus_write(A_SETTLE, 32'd0);
    bus_write(A_CHAN, 32'd5);
    wait_idle();
    bus_write(A_START, 32'd0);
    n = 0;
    while (!adc_eoc && n < 1000) begin @(negedge clk); n++; end
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = A_STATUS;
    #1 check("R6 busy after capture", bus_rdata[0], 32'd1);
    @(negedge clk);
    #1 check("R6 idle one cycle later", bus_rdata[0], 32'd0);
    @(negedge clk);
    bus_addr = A_DATA;
    last_code = expect_code(5);
    #1 check("R6 captured data", bus_rdata, {16'h0, last_code});
    @(negedge clk);
    bus_rd = 1'b0;

    // R5 result holds across a channel change without conversion
    bus_write(A_CHAN, 32'd1);
    wait_idle();
    bus_read(A_DATA, rd);
    check("R5 result holds", rd, {16'h0, last_code});

    // R9 requests during busy are ignored and flagged
    bus_write(A_CHAN, 32'd2);
    wait_idle();
    sc = start_count;
    bus_write(A_START, 32'd0);
    bus_write(A_CHAN, 32'd6);
    bus_write(A_START, 32'd0);
    check("R9 mux unchanged", {28'h0, mux_sel}, 32'd5);
    bus_read(A_STATUS, rd);
    check("R9 overrun set", rd[1:0], 32'd3);
    bus_read(A_STATUS, rd);
    check("R9 overrun cleared", rd[1], 32'd0);
    wait_idle();
    check("R9 single start", start_count - sc, 32'd1);
    last_code = expect_code(2);
    bus_read(A_DATA, rd);
    check("R9 result from first start", rd, {16'h0, last_code});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule